// File: doc/BRIEF.md
# Register Write-Access Lockout Gate

This block sits on the register bus in front of a timekeeping peripheral. It holds one 32-bit permission register. Each of its low eight bits decides whether software may write one protected target register. A bus write addressed to a target produces that target's write strobe only while the matching permission bit is 1. If the bit is 0, the write is dropped and the target keeps its old contents.

Software can only clear permission bits, never set them. A bit that has been cleared comes back only when the system reset is asserted. The block also takes a battery-domain power-on reset and a software reset. Neither of these touches the permission bits. Together with the system reset, they drive the reset output that goes to the protected registers.

The bus uses word addresses. Target k sits at word address k, and the permission register sits at word address 8. The targets and the bus fabric are outside this block.

Top module: `wr_access_gate`

## Requirements
- R1: After the system reset, a read of the permission register (word address 8) returns 0x000000FF.
- R2: Permission bit k gates the target at word address k. The assignment is: bit 7 interrupt enable, bit 6 lock, bit 5 status, bit 4 control, bit 3 time compensation, bit 2 time alarm, bit 1 time prescaler, bit 0 time seconds. While bit k is 1, a write to address k raises `tgt_wr_stb[k]` in the same cycle as the write and raises no other strobe.
- R3: While permission bit k is 0, a write to address k raises no strobe.
- R4: Writing the permission register clears every bit k for which write-data bit k is 0. Write-data bits that are 1 leave the matching permission bit unchanged, so a cleared bit stays cleared.
- R5: A clear takes effect at the clock edge of the write that performs it. A target write in the very next cycle is already gated by the new value.
- R6: Asserting the battery-domain reset (`bat_por_n` low) or the software reset (`sw_rst` high) leaves all permission bits unchanged. A permission write made in the same cycle still takes effect.
- R7: Only the system reset (`sys_rst_n` low) sets cleared permission bits back to 1.
- R8: Write-data bits 31 to 8 have no effect, and reads of the permission register return 0 in bits 31 to 8.
- R9: `tgt_rst_n` is low whenever `sys_rst_n` is low, `bat_por_n` is low or `sw_rst` is high, and high otherwise.
- R10: Reads raise no target strobe. A read of any address other than 8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; the only reset that restores the permission bits |
| bat_por_n | input | 1 | Battery-domain power-on reset, active low |
| sw_rst | input | 1 | Software reset, active high |
| bus_sel | input | 1 | Bus access valid in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tgt_wr_stb | output | 8 | Per-target write strobes, after gating |
| tgt_rst_n | output | 1 | Combined reset for the protected registers, active low |

## Verification
The case where two functions meet in one cycle is a permission-register write that lands while the software reset or the battery-domain reset is asserted. The bench drives both in the same cycle. It then checks two things: that `tgt_rst_n` is low during that cycle, and that the later read shows the clear applied with every other bit intact. It also places a target write in the cycle right after a clear. That write must already be blocked.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int DATA_W    = 32;
  localparam int N_TGT     = 8;
  localparam int ADDR_W    = 4;
  localparam int GATE_ADDR = 8;

  typedef logic [N_TGT-1:0] perm_t;

  // permission bits only ever fall: keep a bit where the write carries 1
  function automatic perm_t perm_after_write(input perm_t cur, input perm_t wbits);
    return cur & wbits;
  endfunction

  // read word: permission bits in the low byte, zero above
  function automatic logic [DATA_W-1:0] gate_read_word(input perm_t cur);
    logic [DATA_W-1:0] w;
    w = '0;
    w[N_TGT-1:0] = cur;
    return w;
  endfunction
endpackage

// File: rtl/wag_decode.sv
module wag_decode #(
  parameter int ADDR_W    = 4,
  parameter int N_TGT     = 8,
  parameter int GATE_ADDR = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TGT-1:0]  tgt_hit,
  output logic              gate_wr,
  output logic              gate_rd
);
  localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_ADDR);

  logic wr_cyc;
  assign wr_cyc = sel & wr;

  for (genvar k = 0; k < N_TGT; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] TA = ADDR_W'(k);
    assign tgt_hit[k] = wr_cyc & (addr == TA);
  end

  assign gate_wr = wr_cyc & (addr == GATE_A);
  assign gate_rd = sel & ~wr & (addr == GATE_A);
endmodule

// File: rtl/wag_perm.sv
module wag_perm
  import wag_pkg::*;
(
  input  logic  clk,
  input  logic  sys_rst_n,
  input  logic  gate_wr,
  input  perm_t wr_bits,
  output perm_t perm
);
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)
      perm <= '1;
    else if (gate_wr)
      perm <= perm_after_write(perm, wr_bits);
  end
endmodule

// File: rtl/wag_gate.sv
module wag_gate #(
  parameter int N_TGT = 8
) (
  input  logic [N_TGT-1:0] tgt_hit,
  input  logic [N_TGT-1:0] perm,
  output logic [N_TGT-1:0] stb,
  output logic [N_TGT-1:0] blocked
);
  for (genvar k = 0; k < N_TGT; k++) begin : g_lane
    assign stb[k]     = tgt_hit[k] & perm[k];
    assign blocked[k] = tgt_hit[k] & ~perm[k];
  end
endmodule

// File: rtl/wr_access_gate.sv
module wr_access_gate
  import wag_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              bat_por_n,
  input  logic              sw_rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TGT-1:0]  tgt_wr_stb,
  output logic              tgt_rst_n
);
  // named internal events for the checker
  logic [N_TGT-1:0] tgt_hit;
  logic [N_TGT-1:0] blocked;
  logic             gate_wr;
  logic             gate_rd;
  perm_t            perm;

  wag_decode #(.ADDR_W(ADDR_W), .N_TGT(N_TGT), .GATE_ADDR(GATE_ADDR)) u_dec (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .tgt_hit (tgt_hit),
    .gate_wr (gate_wr),
    .gate_rd (gate_rd)
  );

  wag_perm u_perm (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .gate_wr   (gate_wr),
    .wr_bits   (bus_wdata[N_TGT-1:0]),
    .perm      (perm)
  );

  wag_gate #(.N_TGT(N_TGT)) u_gate (
    .tgt_hit (tgt_hit),
    .perm    (perm),
    .stb     (tgt_wr_stb),
    .blocked (blocked)
  );

  assign bus_rdata = gate_rd ? gate_read_word(perm) : '0;
  assign tgt_rst_n = sys_rst_n & bat_por_n & ~sw_rst;
endmodule

// File: rtl/wag_chk.sv
module wag_chk
  import wag_pkg::*;
(
  input logic              clk,
  input logic              sys_rst_n,
  input logic              bat_por_n,
  input logic              sw_rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_TGT-1:0]  tgt_wr_stb,
  input logic [N_TGT-1:0]  blocked,
  input logic              tgt_rst_n,
  input logic              gate_wr,
  input perm_t             perm
);
  // R7
  perm_never_rises_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (perm & ~$past(perm)) == '0);

  // R3
  no_stb_when_locked_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (tgt_wr_stb & ~perm) == '0);

  // R4
  clear_applies_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    gate_wr |=> perm == ($past(perm) & $past(bus_wdata[N_TGT-1:0])));

  // R6
  perm_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !gate_wr |=> $stable(perm));

  // R2
  one_stb_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $onehot0(tgt_wr_stb | blocked));

  // R10
  read_no_stb_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_sel & ~bus_wr) |-> tgt_wr_stb == '0);

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    bus_rdata[DATA_W-1:N_TGT] == '0);

  // R9
  tgt_rst_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (sw_rst | ~bat_por_n) |-> !tgt_rst_n);
endmodule

bind wr_access_gate wag_chk u_chk (
  .clk        (clk),
  .sys_rst_n  (sys_rst_n),
  .bat_por_n  (bat_por_n),
  .sw_rst     (sw_rst),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tgt_wr_stb (tgt_wr_stb),
  .blocked    (blocked),
  .tgt_rst_n  (tgt_rst_n),
  .gate_wr    (gate_wr),
  .perm       (perm)
);

// File: tb/test_wr_access_gate.sv
module test_wr_access_gate;
  logic        clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        bat_por_n = 1'b1;
  logic        sw_rst = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tgt_wr_stb;
  logic        tgt_rst_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_perm;

  always #4 clk = ~clk;

  wr_access_gate i_wr_access_gate (
    .clk(clk), .sys_rst_n(sys_rst_n), .bat_por_n(bat_por_n), .sw_rst(sw_rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tgt_wr_stb(tgt_wr_stb), .tgt_rst_n(tgt_rst_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at the falling edge, let combinational outputs settle, then leave
  task automatic drive(input logic wr, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic read_gate(input string req);
    drive(1'b0, 4'd8, 32'h0);
    check(req, bus_rdata, {24'h0, exp_perm});
    check(req, {24'h0, tgt_wr_stb}, 32'h0);
  endtask

  task automatic write_gate(input logic [31:0] d);
    drive(1'b1, 4'd8, d);
    exp_perm = exp_perm & d[7:0];
  endtask

  task automatic sweep_targets(input string req);
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 4'(k), 32'h1234_5678);
      check(req, {24'h0, tgt_wr_stb}, exp_perm[k] ? (32'h1 << k) : 32'h0);
    end
    idle();
  endtask

  task automatic t_reset();
    exp_perm = 8'hFF;
    read_gate("R1");
    check("R9", {31'h0, tgt_rst_n}, 32'h1);
    idle();
  endtask

  task automatic t_map();
    sweep_targets("R2");
  endtask

  task automatic t_reads();
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 4'(a), 32'h0);
      check("R10", bus_rdata, 32'h0);
      check("R10", {24'h0, tgt_wr_stb}, 32'h0);
    end
    idle();
  endtask

  task automatic t_reserved();
    write_gate(32'hA5C3_F0FF);
    idle();
    read_gate("R8");
    idle();
  endtask

  task automatic t_clear();
    write_gate(32'hFFFF_FF5B);
    idle();
    read_gate("R4");
    sweep_targets("R3");
    write_gate(32'hFFFF_FFFF);
    idle();
    read_gate("R4");
    idle();
  endtask

  task automatic t_next_cycle();
    write_gate(32'h0000_00FE);
    drive(1'b1, 4'd0, 32'h0);
    check("R5", {24'h0, tgt_wr_stb}, 32'h0);
    drive(1'b1, 4'd4, 32'h0);
    check("R5", {24'h0, tgt_wr_stb}, 32'h10);
    idle();
  endtask

  task automatic t_side_resets();
    @(negedge clk);
    sw_rst = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 32'hFFFF_FFEF;
    exp_perm = exp_perm & 8'hEF;
    #1;
    check("R9", {31'h0, tgt_rst_n}, 32'h0);
    @(negedge clk);
    sw_rst = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
    check("R9", {31'h0, tgt_rst_n}, 32'h1);
    read_gate("R6");
    idle();
    bat_por_n = 1'b0;
    #1;
    check("R9", {31'h0, tgt_rst_n}, 32'h0);
    repeat (3) @(negedge clk);
    bat_por_n = 1'b1;
    read_gate("R6");
    sweep_targets("R6");
  endtask

  task automatic t_sys_reset();
    @(negedge clk);
    sys_rst_n = 1'b0;
    #1;
    check("R9", {31'h0, tgt_rst_n}, 32'h0);
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    exp_perm = 8'hFF;
    read_gate("R7");
    sweep_targets("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    t_reset();
    t_map();
    t_reads();
    t_reserved();
    t_clear();
    t_next_cycle();
    t_side_resets();
    t_sys_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule